// File: doc/BRIEF.md
# Variable-Page Range-Matching TLB

This block is a fully associative address translation buffer. Each entry maps a virtual range that starts on a page boundary. Entries written by the block's own allocator cover the base page size multiplied by a power of four. Entries placed by software cover any whole number of pages. A combinational lookup port compares an address against every valid entry at once. It returns hit, the matching entry index and the translated physical address. When several entries match, the lowest index wins.

The entry array has two groups. The lowest `N_BLK` indices are block slots that software fills by slot number. They survive every ordinary purge. The remaining indices are ordinary entries. The block places these itself: it takes the lowest free entry first, and when none is free it uses a rotating victim pointer that never lands on a block slot.

Maintenance work arrives on a one-command-at-a-time port. A command is accepted when `cmd_busy` is low. `cmd_done` pulses when the command has finished, and `cmd_status` holds the result of the most recent command. Operations that scan the array for overlaps take one cycle per entry.

Top module: `vprange_tlb`

## Requirements
- R1: After reset, `cmd_busy` and `cmd_done` are low, every entry is invalid, every ordinary entry is free, and every lookup misses.
- R2: An ordinary insert (cmd_op 0) with size code c covers 2^(PAGE_BITS+2c) bytes. Its virtual base is `cmd_va` aligned down to that size, and its last address is that base plus the size minus one.
- R3: The stored physical base of an ordinary insert is `cmd_pa` with the bits at and above PA_W dropped, aligned down to the range size.
- R4: Before an ordinary insert is placed, every valid ordinary entry whose range overlaps the new range is invalidated and freed. Block slots are not touched.
- R5: Placement takes the lowest-indexed free ordinary entry. If no entry is free, it uses the victim index, which is forced to N_BLK when it lies below N_BLK or at or beyond N_ENT, and then advances by one.
- R6: A lookup hits when some entry is valid with base ≤ `lk_va` ≤ last. The lowest such index is reported, and `lk_pa` = physical base + (`lk_va` − base), truncated to PA_W bits.
- R7: A range purge (cmd_op 1) takes its size code c from `cmd_va[3:0]`. It starts at `cmd_va` with the page offset cleared, spans 2^(PAGE_BITS+2c) bytes, and invalidates only the overlapping ordinary entries.
- R8: Purge-all (cmd_op 2) invalidates and frees every ordinary entry, sets the victim index to N_BLK, and keeps valid block slots.
- R9: A block insert (cmd_op 3) writes slot `cmd_slot` with base `cmd_vpn`·page, last base + `cmd_len`·page − 1, and physical base `cmd_ppn`·page. If the slot is N_BLK or higher, or the length is zero, status is 1 (bad argument) and nothing changes.
- R10: A slot purge (cmd_op 4) invalidates block slot `cmd_slot`, or returns status 1 and changes nothing when the slot is N_BLK or higher. Purge-all-block (cmd_op 5) invalidates every block slot and keeps ordinary entries.
- R11: Status 0 means success. `cmd_done` is a one-cycle pulse taken with `cmd_busy` low. Measured in cycles from the acceptance edge to the edge that raises done, a range purge takes N_ENT, an ordinary insert N_ENT+1, and every other command 1. Commands that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_idx | output | IDX_W | Index of the matching entry |
| lk_pa | output | PA_W | Translated physical address (zero on a miss) |
| cmd_valid | input | 1 | Command request, sampled while not busy |
| cmd_op | input | 3 | Operation code |
| cmd_va | input | VA_W | Virtual address for insert or range purge |
| cmd_pa | input | VA_W | Physical address for an ordinary insert |
| cmd_code | input | 4 | Size code for an ordinary insert |
| cmd_slot | input | IDX_W | Block slot number |
| cmd_vpn | input | VA_W-PAGE_BITS | Block insert virtual page |
| cmd_ppn | input | PA_W-PAGE_BITS | Block insert physical page |
| cmd_len | input | VA_W-PAGE_BITS | Block insert length in pages |
| cmd_busy | output | 1 | A command is in progress |
| cmd_done | output | 1 | Command finished (one-cycle pulse) |
| cmd_status | output | 1 | Result of the last command: 0 ok, 1 bad argument |

## Verification
The assertions run on every cycle and cover these properties:
- The done pulse lasts one cycle and never overlaps busy.
- The victim index stays within the ordinary group.
- No entry is both free and valid.
- A reported hit really contains the address, and no lower index also contains it.
- A block slot loses its valid bit only while a slot purge or purge-all-block is the current command.

Some behaviour cannot be checked that way and is left to the bench's scenarios:
- the arithmetic of range sizes and alignment;
- physical truncation;
- the exact choice between the free-entry path and the victim path;
- which entries a purge of a given span removes;
- the per-command latencies.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [2:0] OP_INSERT        = 3'd0;
  localparam logic [2:0] OP_PURGE_RANGE   = 3'd1;
  localparam logic [2:0] OP_PURGE_ALL     = 3'd2;
  localparam logic [2:0] OP_BLK_INSERT    = 3'd3;
  localparam logic [2:0] OP_PURGE_SLOT    = 3'd4;
  localparam logic [2:0] OP_PURGE_BLK_ALL = 3'd5;

  localparam logic STS_OK     = 1'b0;
  localparam logic STS_BADARG = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_ALLOC = 2'd2,
    ST_EXEC  = 2'd3
  } tlb_state_e;
endpackage

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_range_lookup.sv
module tlb_range_lookup #(
  parameter int N    = 8,
  parameter int VA_W = 32,
  parameter int PA_W = 28,
  parameter int IW   = 3
) (
  input  logic [N-1:0]    valid,
  input  logic [VA_W-1:0] base [N],
  input  logic [VA_W-1:0] last [N],
  input  logic [PA_W-1:0] pbase [N],
  input  logic [VA_W-1:0] va,
  output logic            hit,
  output logic [IW-1:0]   idx,
  output logic [PA_W-1:0] pa
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (va >= base[g]) && (va <= last[g]);
  end

  tlb_prio_enc #(.W(N), .IW(IW)) sel_i (
    .req   (match),
    .found (hit),
    .idx   (idx)
  );

  assign pa = hit ? (pbase[idx] + PA_W'(va - base[idx])) : '0;
endmodule

// File: rtl/vprange_tlb.sv
module vprange_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 28,
  parameter int PAGE_BITS = 12,
  parameter int N_ENT     = 8,
  parameter int N_BLK     = 2,
  parameter int CODE_W    = 4,
  localparam int IDX_W    = $clog2(N_ENT),
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PA_W-1:0]  lk_pa,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [VA_W-1:0]  cmd_va,
  input  logic [VA_W-1:0]  cmd_pa,
  input  logic [3:0]       cmd_code,
  input  logic [IDX_W-1:0] cmd_slot,
  input  logic [VPN_W-1:0] cmd_vpn,
  input  logic [PPN_W-1:0] cmd_ppn,
  input  logic [VPN_W-1:0] cmd_len,
  output logic             cmd_busy,
  output logic             cmd_done,
  output logic             cmd_status
);
  localparam int VIC_W = IDX_W + 1;
  localparam logic [VIC_W-1:0] FIRST_ORD = VIC_W'(N_BLK);
  localparam logic [VIC_W-1:0] VIC_END   = VIC_W'(N_ENT);
  localparam logic [IDX_W-1:0] BLK_LIM   = IDX_W'(N_BLK);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(N_ENT - 1);
  localparam logic [N_ENT-1:0] ORD_MASK  = {N_ENT{1'b1}} << N_BLK;
  localparam logic [VA_W-1:0]  PG_OFS    = VA_W'((64'd1 << PAGE_BITS) - 64'd1);

  // Byte-offset mask of a range whose size is the page scaled by 4^code
  function automatic logic [VA_W-1:0] span_mask(input logic [CODE_W-1:0] code);
    logic [VA_W-1:0] m;
    int sh;
    sh = PAGE_BITS + 2 * int'(code);
    for (int i = 0; i < VA_W; i++) m[i] = (i < sh);
    return m;
  endfunction

  // Reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tlb_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [VIC_W-1:0]  victim_q, victim_d;
  logic [N_ENT-1:0]  free_q, free_d;
  logic [N_ENT-1:0]  valid_q, valid_d;
  logic [VA_W-1:0]   base_q [N_ENT];
  logic [VA_W-1:0]   base_d [N_ENT];
  logic [VA_W-1:0]   last_q [N_ENT];
  logic [VA_W-1:0]   last_d [N_ENT];
  logic [PA_W-1:0]   pa_q   [N_ENT];
  logic [PA_W-1:0]   pa_d   [N_ENT];
  logic [2:0]        op_q, op_d;
  logic [VA_W-1:0]   rbase_q, rbase_d, rlast_q, rlast_d;
  logic [PA_W-1:0]   rpa_q, rpa_d;
  logic [IDX_W-1:0]  rslot_q, rslot_d;
  logic              rbad_q, rbad_d;
  logic              done_q, done_d;
  logic              status_q, status_d;

  // Request decode
  logic [VA_W-1:0] ins_m, ins_base, pr_m, pr_base, blk_base;
  always_comb begin
    ins_m    = span_mask(cmd_code);
    ins_base = cmd_va & ~ins_m;
    pr_m     = span_mask(cmd_va[CODE_W-1:0]);
    pr_base  = cmd_va & ~PG_OFS;
    blk_base = {cmd_vpn, {PAGE_BITS{1'b0}}};
  end

  // Lowest free ordinary entry
  logic             fr_found;
  logic [IDX_W-1:0] fr_idx;
  tlb_prio_enc #(.W(N_ENT), .IW(IDX_W)) free_sel_i (
    .req   (free_q),
    .found (fr_found),
    .idx   (fr_idx)
  );

  tlb_range_lookup #(.N(N_ENT), .VA_W(VA_W), .PA_W(PA_W), .IW(IDX_W)) lookup_i (
    .valid (valid_q),
    .base  (base_q),
    .last  (last_q),
    .pbase (pa_q),
    .va    (lk_va),
    .hit   (lk_hit),
    .idx   (lk_idx),
    .pa    (lk_pa)
  );

  // Next-state logic
  logic [IDX_W-1:0] tgt;
  logic [VIC_W-1:0] vic;
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    victim_d = victim_q;
    free_d   = free_q;
    valid_d  = valid_q;
    base_d   = base_q;
    last_d   = last_q;
    pa_d     = pa_q;
    op_d     = op_q;
    rbase_d  = rbase_q;
    rlast_d  = rlast_q;
    rpa_d    = rpa_q;
    rslot_d  = rslot_q;
    rbad_d   = rbad_q;
    done_d   = 1'b0;
    status_d = status_q;
    tgt      = '0;
    vic      = victim_q;

    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          op_d    = cmd_op;
          rslot_d = cmd_slot;
          idx_d   = '0;
          rbad_d  = (cmd_slot >= BLK_LIM) ||
                    ((cmd_op == OP_BLK_INSERT) && (cmd_len == '0));
          if (cmd_op == OP_PURGE_RANGE) begin
            rbase_d = pr_base;
            rlast_d = pr_base + pr_m;
          end else if (cmd_op == OP_BLK_INSERT) begin
            rbase_d = blk_base;
            rlast_d = blk_base + {cmd_len, {PAGE_BITS{1'b0}}} - VA_W'(1);
            rpa_d   = {cmd_ppn, {PAGE_BITS{1'b0}}};
          end else begin
            rbase_d = ins_base;
            rlast_d = ins_base | ins_m;
            rpa_d   = PA_W'(cmd_pa) & ~PA_W'(ins_m);
          end
          st_d = ((cmd_op == OP_INSERT) || (cmd_op == OP_PURGE_RANGE)) ? ST_SCAN : ST_EXEC;
        end
      end
      ST_SCAN: begin
        if ((idx_q >= BLK_LIM) && valid_q[idx_q] &&
            (base_q[idx_q] <= rlast_q) && (last_q[idx_q] >= rbase_q)) begin
          valid_d[idx_q] = 1'b0;
          free_d[idx_q]  = 1'b1;
        end
        if (idx_q == LAST_IDX) begin
          if (op_q == OP_INSERT) begin
            st_d = ST_ALLOC;
          end else begin
            st_d     = ST_IDLE;
            done_d   = 1'b1;
            status_d = STS_OK;
          end
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_ALLOC: begin
        if (fr_found) begin
          tgt         = fr_idx;
          free_d[tgt] = 1'b0;
        end else begin
          if ((victim_q < FIRST_ORD) || (victim_q >= VIC_END)) vic = FIRST_ORD;
          tgt      = vic[IDX_W-1:0];
          victim_d = vic + VIC_W'(1);
        end
        valid_d[tgt] = 1'b1;
        base_d[tgt]  = rbase_q;
        last_d[tgt]  = rlast_q;
        pa_d[tgt]    = rpa_q;
        st_d         = ST_IDLE;
        done_d       = 1'b1;
        status_d     = STS_OK;
      end
      default: begin
        status_d = STS_OK;
        unique case (op_q)
          OP_PURGE_ALL: begin
            for (int i = 0; i < N_ENT; i++) begin
              if (i >= N_BLK) begin
                valid_d[i] = 1'b0;
                free_d[i]  = 1'b1;
              end
            end
            victim_d = FIRST_ORD;
          end
          OP_BLK_INSERT: begin
            if (rbad_q) begin
              status_d = STS_BADARG;
            end else begin
              valid_d[rslot_q] = 1'b1;
              base_d[rslot_q]  = rbase_q;
              last_d[rslot_q]  = rlast_q;
              pa_d[rslot_q]    = rpa_q;
            end
          end
          OP_PURGE_SLOT: begin
            if (rbad_q) status_d = STS_BADARG;
            else        valid_d[rslot_q] = 1'b0;
          end
          OP_PURGE_BLK_ALL: begin
            for (int i = 0; i < N_BLK; i++) valid_d[i] = 1'b0;
          end
          default: ;
        endcase
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      victim_q <= FIRST_ORD;
      free_q   <= ORD_MASK;
      valid_q  <= '0;
      op_q     <= '0;
      rbase_q  <= '0;
      rlast_q  <= '0;
      rpa_q    <= '0;
      rslot_q  <= '0;
      rbad_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= STS_OK;
      for (int i = 0; i < N_ENT; i++) begin
        base_q[i] <= '0;
        last_q[i] <= '0;
        pa_q[i]   <= '0;
      end
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      victim_q <= victim_d;
      free_q   <= free_d;
      valid_q  <= valid_d;
      op_q     <= op_d;
      rbase_q  <= rbase_d;
      rlast_q  <= rlast_d;
      rpa_q    <= rpa_d;
      rslot_q  <= rslot_d;
      rbad_q   <= rbad_d;
      done_q   <= done_d;
      status_q <= status_d;
      base_q   <= base_d;
      last_q   <= last_d;
      pa_q     <= pa_d;
    end
  end

  assign cmd_busy   = (st_q != ST_IDLE);
  assign cmd_done   = done_q;
  assign cmd_status = status_q;
endmodule

// File: rtl/vprange_tlb_chk.sv
module vprange_tlb_chk
  import tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int N_ENT = 8,
  parameter int N_BLK = 2,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_busy,
  input logic             cmd_done,
  input logic [2:0]       op_q,
  input logic [IDX_W:0]   victim_q,
  input logic [N_ENT-1:0] free_q,
  input logic [N_ENT-1:0] valid_q,
  input logic [VA_W-1:0]  base_q [N_ENT],
  input logic [VA_W-1:0]  last_q [N_ENT],
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !cmd_busy); // R11
  AST_VICTIM_ORD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(victim_q) >= N_BLK) && (int'(victim_q) <= N_ENT)); // R5
  AST_FREE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q & valid_q) == '0); // R5
  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_q[lk_idx] && (lk_va >= base_q[lk_idx]) && (lk_va <= last_q[lk_idx]))); // R6

  for (genvar g = 0; g < N_ENT; g++) begin : g_low
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && (int'(lk_idx) > g)) |-> !(valid_q[g] && (lk_va >= base_q[g]) && (lk_va <= last_q[g]))); // R6
  end

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    AST_BLK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid_q[g]) |-> ((op_q == OP_PURGE_SLOT) || (op_q == OP_PURGE_BLK_ALL))); // R10
  end
endmodule

bind vprange_tlb vprange_tlb_chk #(
  .VA_W(VA_W), .N_ENT(N_ENT), .N_BLK(N_BLK), .IDX_W(IDX_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cmd_busy (cmd_busy),
  .cmd_done (cmd_done),
  .op_q     (op_q),
  .victim_q (victim_q),
  .free_q   (free_q),
  .valid_q  (valid_q),
  .base_q   (base_q),
  .last_q   (last_q),
  .lk_va    (lk_va),
  .lk_hit   (lk_hit),
  .lk_idx   (lk_idx)
);

// File: tb/vprange_tlb_tb_top.sv
module vprange_tlb_tb_top;
  localparam int N_ENT = 8;

  logic        clk, rst_n;
  logic [31:0] lk_va;
  logic        lk_hit;
  logic [2:0]  lk_idx;
  logic [27:0] lk_pa;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_va, cmd_pa;
  logic [3:0]  cmd_code;
  logic [2:0]  cmd_slot;
  logic [19:0] cmd_vpn, cmd_len;
  logic [15:0] cmd_ppn;
  logic        cmd_busy, cmd_done, cmd_status;

  int n_chk = 0;
  int n_fail = 0;

  vprange_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_pa(lk_pa), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_va(cmd_va),
    .cmd_pa(cmd_pa), .cmd_code(cmd_code), .cmd_slot(cmd_slot), .cmd_vpn(cmd_vpn),
    .cmd_ppn(cmd_ppn), .cmd_len(cmd_len), .cmd_busy(cmd_busy),
    .cmd_done(cmd_done), .cmd_status(cmd_status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one command; lat counts negedges until done is seen
  task automatic issue(input logic [2:0] op, input logic [31:0] va, input logic [31:0] pa,
                       input logic [3:0] code, input logic [2:0] slot, input logic [19:0] vpn,
                       input logic [15:0] ppn, input logic [19:0] len,
                       output int lat, output logic sts);
    @(negedge clk);
    cmd_op = op; cmd_va = va; cmd_pa = pa; cmd_code = code; cmd_slot = slot;
    cmd_vpn = vpn; cmd_ppn = ppn; cmd_len = len; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!cmd_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    sts = cmd_status;
  endtask

  task automatic look(input logic [31:0] va, input bit ehit, input logic [2:0] eidx,
                      input logic [27:0] epa, input string req);
    lk_va = va;
    #1;
    check(lk_hit == ehit, req, 64'(lk_hit), 64'(ehit));
    if (ehit) begin
      check(lk_idx == eidx, req, 64'(lk_idx), 64'(eidx));
      check(lk_pa == epa, req, 64'(lk_pa), 64'(epa));
    end
  endtask

  task automatic ins(input logic [31:0] va, input logic [31:0] pa, input logic [3:0] code,
                     output int lat);
    logic s;
    issue(3'd0, va, pa, code, 3'd0, 20'd0, 16'd0, 20'd0, lat, s);
  endtask

  task automatic t_reset;
    check(cmd_busy == 1'b0, "R1 busy", 64'(cmd_busy), 0);
    check(cmd_done == 1'b0, "R1 done", 64'(cmd_done), 0);
    look(32'h0, 1'b0, 3'd0, 28'd0, "R1 miss0");
    look(32'hFFFF_FFFF, 1'b0, 3'd0, 28'd0, "R1 missF");
  endtask

  task automatic t_insert_basic;
    int lat;
    ins(32'h0001_2345, 32'h0ABC_D000, 4'd0, lat);
    check(lat == N_ENT + 2, "R11 insert latency", 64'(lat), 64'(N_ENT + 2));
    look(32'h0001_2345, 1'b1, 3'd2, 28'hABC_D345, "R6 R5 first free");
    look(32'h0001_3000, 1'b0, 3'd0, 28'd0, "R2 above last");
    look(32'h0001_1FFF, 1'b0, 3'd0, 28'd0, "R2 below base");
  endtask

  task automatic t_insert_large;
    int lat;
    ins(32'h0047_1234, 32'hF123_4567, 4'd2, lat);
    look(32'h0047_ABCD, 1'b1, 3'd3, 28'h123_ABCD, "R3 truncate align");
    look(32'h0047_0000, 1'b1, 3'd3, 28'h123_0000, "R2 aligned base");
    look(32'h0047_FFFF, 1'b1, 3'd3, 28'h123_FFFF, "R2 last");
    look(32'h0048_0000, 1'b0, 3'd0, 28'd0, "R2 past end");
  endtask

  task automatic t_overlap;
    int lat;
    ins(32'h0001_0000, 32'h0500_0000, 4'd1, lat);
    look(32'h0001_2345, 1'b1, 3'd2, 28'h500_2345, "R4 replaced");
    look(32'h0001_0004, 1'b1, 3'd2, 28'h500_0004, "R4 new range");
  endtask

  task automatic t_block;
    int lat; logic s;
    issue(3'd3, 32'd0, 32'd0, 4'd0, 3'd1, 20'h12, 16'h777, 20'd2, lat, s);
    check(s == 1'b0, "R9 status ok", 64'(s), 0);
    check(lat == 2, "R11 single latency", 64'(lat), 2);
    look(32'h0001_2345, 1'b1, 3'd1, 28'h077_7345, "R6 lowest wins");
    look(32'h0001_3FFF, 1'b1, 3'd1, 28'h077_8FFF, "R9 len");
    issue(3'd3, 32'd0, 32'd0, 4'd0, 3'd2, 20'h900, 16'h1, 20'd1, lat, s);
    check(s == 1'b1, "R9 bad slot", 64'(s), 1);
    look(32'h0090_0000, 1'b0, 3'd0, 28'd0, "R9 unchanged slot");
    issue(3'd3, 32'd0, 32'd0, 4'd0, 3'd0, 20'h900, 16'h1, 20'd0, lat, s);
    check(s == 1'b1, "R9 zero len", 64'(s), 1);
    look(32'h0090_0000, 1'b0, 3'd0, 28'd0, "R9 unchanged len");
  endtask

  task automatic t_range_purge;
    int lat; logic s;
    issue(3'd1, 32'h0001_2000, 32'd0, 4'd0, 3'd0, 20'd0, 16'd0, 20'd0, lat, s);
    check(lat == N_ENT + 1, "R11 purge latency", 64'(lat), 64'(N_ENT + 1));
    look(32'h0001_2345, 1'b1, 3'd1, 28'h077_7345, "R7 block kept");
    look(32'h0001_0000, 1'b0, 3'd0, 28'd0, "R7 ordinary gone");
    look(32'h0047_ABCD, 1'b1, 3'd3, 28'h123_ABCD, "R7 disjoint kept");
  endtask

  task automatic t_purge_all;
    int lat; logic s;
    issue(3'd2, 32'd0, 32'd0, 4'd0, 3'd0, 20'd0, 16'd0, 20'd0, lat, s);
    look(32'h0047_ABCD, 1'b0, 3'd0, 28'd0, "R8 ordinary gone");
    look(32'h0001_2345, 1'b1, 3'd1, 28'h077_7345, "R8 block kept");
  endtask

  task automatic t_victim;
    int lat;
    for (int k = 0; k < 8; k++)
      ins(32'h0020_0000 + 32'(k << 12), 32'h0800_0000 + 32'(k << 16), 4'd0, lat);
    look(32'h0020_6010, 1'b1, 3'd2, 28'h806_0010, "R5 victim first ordinary");
    look(32'h0020_7010, 1'b1, 3'd3, 28'h807_0010, "R5 victim advance");
    look(32'h0020_0010, 1'b0, 3'd0, 28'd0, "R5 evicted k0");
    look(32'h0020_1010, 1'b0, 3'd0, 28'd0, "R5 evicted k1");
    look(32'h0020_2010, 1'b1, 3'd4, 28'h802_0010, "R5 free order");
  endtask

  task automatic t_slot_purge;
    int lat; logic s;
    issue(3'd4, 32'd0, 32'd0, 4'd0, 3'd1, 20'd0, 16'd0, 20'd0, lat, s);
    check(s == 1'b0, "R10 slot ok", 64'(s), 0);
    look(32'h0001_2345, 1'b0, 3'd0, 28'd0, "R10 slot cleared");
    issue(3'd4, 32'd0, 32'd0, 4'd0, 3'd5, 20'd0, 16'd0, 20'd0, lat, s);
    check(s == 1'b1, "R10 bad slot", 64'(s), 1);
    look(32'h0020_5010, 1'b1, 3'd7, 28'h805_0010, "R10 ordinary untouched");
  endtask

  task automatic t_blk_all;
    int lat; logic s;
    issue(3'd3, 32'd0, 32'd0, 4'd0, 3'd0, 20'h30, 16'h10, 20'd1, lat, s);
    look(32'h0003_0004, 1'b1, 3'd0, 28'h001_0004, "R9 slot0");
    issue(3'd5, 32'd0, 32'd0, 4'd0, 3'd0, 20'd0, 16'd0, 20'd0, lat, s);
    look(32'h0003_0004, 1'b0, 3'd0, 28'd0, "R10 all block cleared");
    look(32'h0020_2010, 1'b1, 3'd4, 28'h802_0010, "R10 ordinary kept");
  endtask

  task automatic t_purge_span;
    int lat; logic s;
    issue(3'd1, 32'h0020_4001, 32'd0, 4'd0, 3'd0, 20'd0, 16'd0, 20'd0, lat, s);
    look(32'h0020_3010, 1'b1, 3'd5, 28'h803_0010, "R7 below span kept");
    look(32'h0020_4010, 1'b0, 3'd0, 28'd0, "R7 span start");
    look(32'h0020_7010, 1'b0, 3'd0, 28'd0, "R7 span end");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_va = '0; cmd_pa = '0;
    cmd_code = '0; cmd_slot = '0; cmd_vpn = '0; cmd_ppn = '0; cmd_len = '0; lk_va = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_insert_basic();
    t_insert_large();
    t_overlap();
    t_block();
    t_range_purge();
    t_purge_all();
    t_victim();
    t_slot_purge();
    t_blk_all();
    t_purge_span();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule